// File: doc/BRIEF.md
# Iterative Single-Precision Floating-Point Divider

This unit sits beside an in-order integer pipeline and computes the quotient of two IEEE-754 binary32 values read from the general register file. The pipeline raises `start` for one cycle with the dividend on `op_a` and the divisor on `op_b`. The unit captures both words and raises `busy`. Exactly thirty cycles after the accepting edge it raises `done` for one cycle, and the rounded quotient appears on `result`. The quotient is produced one bit per cycle by a restoring recurrence. No second division can overlap the first: a `start` seen while `busy` is high is dropped.

Control is a six-state machine. IDLE waits for `start`. The transition IDLE→UNPACK captures the operands. UNPACK classifies each operand, forms the quotient sign and the biased exponent difference, and loads the recurrence. UNPACK→ITER starts the 26 recurrence steps: 24 significand bits plus two extra bits for guard and round. ITER→NORM is taken on the last step. NORM aligns the quotient and derives the guard and sticky bits. NORM→ROUND applies round-to-nearest-even. ROUND→PACK selects between the special-case word and the packed number and checks for exponent overflow or underflow. PACK→IDLE registers the result and pulses `done`.

Special operands take the same thirty cycles as ordinary ones, so the pipeline can always schedule the write-back slot ahead of time. Subnormal inputs are read as zeros of the same sign, and subnormal results are flushed to zero.

Top module: `fdiv_core`

## Requirements
- R1: After reset, `busy` and `done` are low and `result` is zero. When `start` is sampled high while `busy` is low, both operands are captured at that edge and `busy` is high from the following cycle.
- R2: If a division is accepted at edge 0, `done` is high for exactly one cycle after edge 30 and low after edges 1 to 29. `busy` stays high through edge 29 and is low in the cycle in which `done` is high.
- R3: A `start` sampled while `busy` is high has no effect. The current division still finishes at its original cycle with its own quotient, and no extra `done` pulse follows.
- R4: For finite nonzero operands with a normal result, the quotient is a/b rounded to nearest with ties to even. The biased exponent is ea − eb + 127, reduced by one when the significand ratio is below one and raised by one when rounding carries out of the significand.
- R5: A finite nonzero dividend divided by a zero divisor gives an infinity: exponent field all ones, fraction zero.
- R6: A finite dividend divided by an infinite divisor gives a zero.
- R7: 0/0, ∞/∞, and any division with a NaN operand return the quiet NaN 0x7FC00000 (sign 0, exponent all ones, fraction MSB set).
- R8: Every infinite or zero quotient carries the XOR of the operand signs. An infinite dividend over a finite divisor gives a signed infinity, and a zero dividend over a finite nonzero divisor gives a signed zero.
- R9: A rounded biased exponent of 255 or more gives a signed infinity. One of 0 or less gives a signed zero. Operands with exponent field 0 count as zero, and no result has a zero exponent field with a nonzero fraction.
- R10: `result` changes only in the cycle in which `done` rises and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a division |
| op_a | input | 32 | Dividend, binary32 |
| op_b | input | 32 | Divisor, binary32 |
| busy | output | 1 | High while a division is in flight |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | 32 | Quotient, binary32 |

## Verification
The bound checker watches the handshake on every cycle. It checks that `busy` rises after an accepted start and holds until `done`, that `done` is a single-cycle pulse arriving exactly thirty busy cycles after acceptance, that `result` moves only with `done`, and that no subnormal or non-canonical NaN is ever produced. The numerical results come only from the bench's scenarios: rounding direction, exponent adjustment, overflow and underflow limits, and the sign and class of each special case. The bench compares these against a quotient it computes with whole-number arithmetic. Those scenarios also show that a start sent mid-division leaves the quotient untouched.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNPACK,
        ST_ITER,
        ST_NORM,
        ST_ROUND,
        ST_PACK
    } fdiv_state_e;

    typedef enum logic [1:0] {
        CLS_ZERO,
        CLS_FINITE,
        CLS_INF,
        CLS_NAN
    } fp_class_e;

    typedef enum logic [1:0] {
        OUT_NUMBER,
        OUT_QNAN,
        OUT_INF,
        OUT_ZERO
    } fdiv_outcome_e;

    // Priority: NaN inputs and the two indeterminate forms first,
    // then the infinite results, then the zero results.
    function automatic fdiv_outcome_e pick_outcome(input fp_class_e ca, input fp_class_e cb);
        if (ca == CLS_NAN || cb == CLS_NAN)   return OUT_QNAN;
        if (ca == CLS_INF && cb == CLS_INF)   return OUT_QNAN;
        if (ca == CLS_ZERO && cb == CLS_ZERO) return OUT_QNAN;
        if (ca == CLS_INF || cb == CLS_ZERO)  return OUT_INF;
        if (cb == CLS_INF || ca == CLS_ZERO)  return OUT_ZERO;
        return OUT_NUMBER;
    endfunction

endpackage

// File: rtl/fdiv_classify.sv
module fdiv_classify
    import fdiv_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] operand,
    output logic                  sign,
    output fp_class_e             cls,
    output logic [EXP_W-1:0]      biased_exp,
    output logic [FRAC_W:0]       signif
);

    logic exp_ones;
    logic exp_zero;
    logic frac_zero;

    assign sign       = operand[EXP_W+FRAC_W];
    assign biased_exp = operand[EXP_W+FRAC_W-1:FRAC_W];
    assign exp_ones   = &biased_exp;
    assign exp_zero   = (biased_exp == '0);
    assign frac_zero  = (operand[FRAC_W-1:0] == '0);
    assign signif     = {1'b1, operand[FRAC_W-1:0]};

    always_comb begin
        if (exp_ones)      cls = frac_zero ? CLS_INF : CLS_NAN;
        else if (exp_zero) cls = CLS_ZERO;   // subnormals flushed
        else               cls = CLS_FINITE;
    end

endmodule

// File: rtl/fdiv_recur.sv
module fdiv_recur #(
    parameter int MAN_W = 24,
    parameter int STEPS = MAN_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [MAN_W-1:0]   dividend,
    input  logic [MAN_W-1:0]   divisor,
    output logic [STEPS-1:0]   quotient,
    output logic               rem_nonzero
);

    logic [MAN_W:0]     rem;
    logic [MAN_W-1:0]   dvs;
    logic [MAN_W:0]     next_rem;
    logic               fits;

    // Restoring step: subtract when the partial remainder covers the divisor.
    assign fits     = (rem >= {1'b0, dvs});
    assign next_rem = fits ? (rem - {1'b0, dvs}) : rem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem      <= '0;
            dvs      <= '0;
            quotient <= '0;
        end else if (load) begin
            rem      <= {1'b0, dividend};
            dvs      <= divisor;
            quotient <= '0;
        end else if (step) begin
            rem      <= next_rem << 1;
            quotient <= {quotient[STEPS-2:0], fits};
        end
    end

    assign rem_nonzero = |rem;

endmodule

// File: rtl/fdiv_normalize.sv
module fdiv_normalize #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 24,
    parameter int STEPS = MAN_W + 2
) (
    input  logic [STEPS-1:0]         quotient,
    input  logic                     rem_nonzero,
    input  logic signed [EXP_W+1:0]  exp_in,
    output logic [MAN_W-1:0]         mant,
    output logic                     guard,
    output logic                     sticky,
    output logic signed [EXP_W+1:0]  exp_out
);

    localparam logic signed [EXP_W+1:0] ONE = 1;

    // Quotient lies in (0.5, 2): the top bit decides a one-place shift.
    always_comb begin
        if (quotient[STEPS-1]) begin
            mant    = quotient[STEPS-1:2];
            guard   = quotient[1];
            sticky  = quotient[0] | rem_nonzero;
            exp_out = exp_in;
        end else begin
            mant    = quotient[STEPS-2:1];
            guard   = quotient[0];
            sticky  = rem_nonzero;
            exp_out = exp_in - ONE;
        end
    end

endmodule

// File: rtl/fdiv_round.sv
module fdiv_round #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 24
) (
    input  logic [MAN_W-1:0]         mant,
    input  logic                     guard,
    input  logic                     sticky,
    input  logic signed [EXP_W+1:0]  exp_in,
    output logic [MAN_W-2:0]         frac_out,
    output logic signed [EXP_W+1:0]  exp_out
);

    localparam logic signed [EXP_W+1:0] ONE = 1;

    logic           inc;
    logic [MAN_W:0] sum;

    assign inc = guard & (sticky | mant[0]);
    assign sum = {1'b0, mant} + {{MAN_W{1'b0}}, inc};

    always_comb begin
        if (sum[MAN_W]) begin
            frac_out = sum[MAN_W-1:1];
            exp_out  = exp_in + ONE;
        end else begin
            frac_out = sum[MAN_W-2:0];
            exp_out  = exp_in;
        end
    end

endmodule

// File: rtl/fdiv_core.sv
module fdiv_core
    import fdiv_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [EXP_W+FRAC_W:0]     op_a,
    input  logic [EXP_W+FRAC_W:0]     op_b,
    output logic                      busy,
    output logic                      done,
    output logic [EXP_W+FRAC_W:0]     result
);

    localparam int W       = 1 + EXP_W + FRAC_W;
    localparam int MAN_W   = FRAC_W + 1;
    localparam int STEPS   = MAN_W + 2;
    localparam int EW      = EXP_W + 2;
    localparam int CNT_W   = $clog2(STEPS);
    localparam int LATENCY = STEPS + 4;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;

    localparam logic signed [EW-1:0] BIAS_S = EW'(BIAS);
    localparam logic signed [EW-1:0] TOP_S  = EW'(EXP_MAX);
    localparam logic signed [EW-1:0] ZERO_S = '0;
    localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    fdiv_state_e state, state_nx;

    logic [W-1:0]           opa_q, opb_q;
    logic                   sign_q;
    fdiv_outcome_e          outcome_q;
    logic signed [EW-1:0]   exp_q;
    logic [CNT_W-1:0]       step_cnt;

    logic [MAN_W-1:0]       mant_n;
    logic                   guard_n, sticky_n;
    logic signed [EW-1:0]   exp_n;
    logic [FRAC_W-1:0]      frac_r;
    logic signed [EW-1:0]   exp_r;

    logic                   done_q;
    logic [W-1:0]           result_q;
    logic [W-1:0]           packed_word;

    // ---------------- operand classification ----------------
    logic [W-1:0]       ops    [2];
    logic               sign_c [2];
    fp_class_e          cls_c  [2];
    logic [EXP_W-1:0]   exp_c  [2];
    logic [MAN_W-1:0]   sig_c  [2];

    assign ops[0] = opa_q;
    assign ops[1] = opb_q;

    for (genvar g = 0; g < 2; g++) begin : g_cls
        fdiv_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .operand    (ops[g]),
            .sign       (sign_c[g]),
            .cls        (cls_c[g]),
            .biased_exp (exp_c[g]),
            .signif     (sig_c[g])
        );
    end

    // ---------------- significand recurrence ----------------
    logic [STEPS-1:0] quo;
    logic             rem_nz;

    fdiv_recur #(.MAN_W(MAN_W), .STEPS(STEPS)) u_recur (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (state == ST_UNPACK),
        .step        (state == ST_ITER),
        .dividend    (sig_c[0]),
        .divisor     (sig_c[1]),
        .quotient    (quo),
        .rem_nonzero (rem_nz)
    );

    // ---------------- normalise and round ----------------
    logic [MAN_W-1:0]     mant_c;
    logic                 guard_c, sticky_c;
    logic signed [EW-1:0] exp_nc;
    logic [FRAC_W-1:0]    frac_c;
    logic signed [EW-1:0] exp_rc;

    fdiv_normalize #(.EXP_W(EXP_W), .MAN_W(MAN_W), .STEPS(STEPS)) u_norm (
        .quotient    (quo),
        .rem_nonzero (rem_nz),
        .exp_in      (exp_q),
        .mant        (mant_c),
        .guard       (guard_c),
        .sticky      (sticky_c),
        .exp_out     (exp_nc)
    );

    fdiv_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_round (
        .mant     (mant_n),
        .guard    (guard_n),
        .sticky   (sticky_n),
        .exp_in   (exp_n),
        .frac_out (frac_c),
        .exp_out  (exp_rc)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_UNPACK;
            ST_UNPACK: state_nx = ST_ITER;
            ST_ITER:   if (step_cnt == CNT_W'(STEPS - 1)) state_nx = ST_NORM;
            ST_NORM:   state_nx = ST_ROUND;
            ST_ROUND:  state_nx = ST_PACK;
            ST_PACK:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opa_q     <= '0;
            opb_q     <= '0;
            sign_q    <= 1'b0;
            outcome_q <= OUT_NUMBER;
            exp_q     <= '0;
            step_cnt  <= '0;
            mant_n    <= '0;
            guard_n   <= 1'b0;
            sticky_n  <= 1'b0;
            exp_n     <= '0;
            frac_r    <= '0;
            exp_r     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        opa_q <= op_a;
                        opb_q <= op_b;
                    end
                end
                ST_UNPACK: begin
                    sign_q    <= sign_c[0] ^ sign_c[1];
                    outcome_q <= pick_outcome(cls_c[0], cls_c[1]);
                    exp_q     <= signed'({2'b00, exp_c[0]}) - signed'({2'b00, exp_c[1]}) + BIAS_S;
                    step_cnt  <= '0;
                end
                ST_ITER: begin
                    step_cnt <= step_cnt + 1'b1;
                end
                ST_NORM: begin
                    mant_n   <= mant_c;
                    guard_n  <= guard_c;
                    sticky_n <= sticky_c;
                    exp_n    <= exp_nc;
                end
                ST_ROUND: begin
                    frac_r <= frac_c;
                    exp_r  <= exp_rc;
                end
                default: ;
            endcase
        end
    end

    // ---------------- result selection ----------------
    always_comb begin
        packed_word = '0;
        unique case (outcome_q)
            OUT_QNAN: packed_word = QNAN;
            OUT_INF:  packed_word = {sign_q, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            OUT_ZERO: packed_word = {sign_q, {(W-1){1'b0}}};
            OUT_NUMBER: begin
                if (exp_r >= TOP_S)
                    packed_word = {sign_q, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
                else if (exp_r <= ZERO_S)
                    packed_word = {sign_q, {(W-1){1'b0}}};
                else
                    packed_word = {sign_q, exp_r[EXP_W-1:0], frac_r};
            end
            default: packed_word = QNAN;
        endcase
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= (state == ST_PACK);
            if (state == ST_PACK) result_q <= packed_word;
        end
    end

    assign busy   = (state != ST_IDLE);
    assign done   = done_q;
    assign result = result_q;

endmodule

// File: rtl/fdiv_checker.sv
module fdiv_checker #(
    parameter int W       = 32,
    parameter int FRAC_W  = 23,
    parameter int LATENCY = 30
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result
);

    localparam int CW = $clog2(LATENCY + 2);
    localparam logic [W-1:0] QNAN = {1'b0, {(W-1-FRAC_W){1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [CW-1:0] lat_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              lat_cnt <= '0;
        else if (start && !busy) lat_cnt <= '0;
        else if (busy)           lat_cnt <= lat_cnt + 1'b1;
    end

    assert_busy_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_fixed_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == CW'(LATENCY)));

    assert_busy_low_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    assert_canonical_nan_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (&result[W-2:FRAC_W]) && (|result[FRAC_W-1:0])) |-> (result == QNAN));

    assert_no_denormal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (result[W-2:FRAC_W] == '0)) |-> (result[FRAC_W-1:0] == '0));

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

endmodule

bind fdiv_core fdiv_checker #(
    .W       (W),
    .FRAC_W  (FRAC_W),
    .LATENCY (LATENCY)
) u_fdiv_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/tb_fdiv_core.sv
`timescale 1ns/1ps
module tb_fdiv_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        busy, done;
    logic [31:0] result;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    fdiv_core dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .result(result)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference quotient from whole-number arithmetic on the significands.
    function automatic logic [31:0] ref_div(input logic [31:0] a, input logic [31:0] b);
        logic   s;
        int     ea, eb, e;
        longint ma, mb, num, q, r, m;
        bit     g, st, na, nb, ia, ib, za, zb;
        s  = a[31] ^ b[31];
        ea = {24'b0, a[30:23]};
        eb = {24'b0, b[30:23]};
        na = (ea == 255) && (a[22:0] != 0);
        nb = (eb == 255) && (b[22:0] != 0);
        ia = (ea == 255) && (a[22:0] == 0);
        ib = (eb == 255) && (b[22:0] == 0);
        za = (ea == 0);
        zb = (eb == 0);
        if (na || nb || (ia && ib) || (za && zb)) return 32'h7FC00000;
        if (ia || zb) return {s, 8'hFF, 23'h0};
        if (ib || za) return {s, 31'h0};
        ma  = {40'b0, 1'b1, a[22:0]};
        mb  = {40'b0, 1'b1, b[22:0]};
        num = ma << 25;
        q   = num / mb;
        r   = num % mb;
        e   = ea - eb + 127;
        if (q >= (64'sd1 << 25)) begin
            m = q >> 2; g = q[1]; st = q[0] || (r != 0);
        end else begin
            m = q >> 1; g = q[0]; st = (r != 0); e = e - 1;
        end
        if (g && (st || m[0])) m = m + 1;
        if (m == (64'sd1 << 24)) begin
            m = 64'sd1 << 23; e = e + 1;
        end
        if (e >= 255) return {s, 8'hFF, 23'h0};
        if (e <= 0)   return {s, 31'h0};
        return {s, e[7:0], m[22:0]};
    endfunction

    function automatic logic [22:0] frac_pick(input int i);
        logic [31:0] h;
        case (i)
            0: return 23'h000000;
            1: return 23'h7FFFFF;
            2: return 23'h400000;
            3: return 23'h000001;
            4: return 23'h555555;
            5: return 23'h2AAAAA;
            default: begin
                h = i * 32'h9E3779B1;
                return h[27:5];
            end
        endcase
    endfunction

    // class: 0 zero, 1 subnormal, 2 normal, 3 infinity, 4 NaN
    function automatic logic [31:0] mk(input int cls, input bit s);
        case (cls)
            0: return {s, 31'h0};
            1: return {s, 8'h00, 23'h000123};
            2: return {s, 8'd130, 23'h1234AB};
            3: return {s, 8'hFF, 23'h0};
            default: return {s, 8'hFF, 23'h400001};
        endcase
    endfunction

    task automatic run_div(input logic [31:0] a, input logic [31:0] b, input string req, input bit poke);
        logic [31:0] expv, prev;
        int late, moved;
        expv = ref_div(a, b);
        @(negedge clk);
        prev  = result;
        start = 1'b1; op_a = a; op_b = b;
        @(negedge clk);
        start = 1'b0; op_a = '0; op_b = '0;
        chk(busy === 1'b1 && done === 1'b0, "R1", {30'b0, busy, done}, 32'h2);
        late = 0; moved = 0;
        for (int k = 1; k < 30; k++) begin
            if (poke && k == 5) begin
                start = 1'b1; op_a = 32'h3F800000; op_b = 32'h40400000;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            if (done !== 1'b0 || busy !== 1'b1) late++;
            if (result !== prev) moved++;
        end
        start = 1'b0;
        @(negedge clk);
        chk(late == 0 && done === 1'b1 && busy === 1'b0, "R2", {late[29:0], busy, done}, 32'h1);
        chk(moved == 0, "R10", moved, 0);
        chk(result === expv, req, result, expv);
        if (poke) begin
            late = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (done !== 1'b0 || busy !== 1'b0) late++;
                if (result !== expv) moved++;
            end
            chk(late == 0, "R3", late, 0);
            chk(moved == 0 && result === expv, "R3", result, expv);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R1", {30'b0, busy, done}, 32'h0);
        chk(result === 32'h0, "R1", result, 32'h0);
        rst_n = 1'b1;

        // R3: restart attempts mid-division are dropped
        run_div(32'h40490FDB, 32'h402DF854, "R3", 1'b1);
        run_div(32'h3F800000, 32'h40400000, "R3", 1'b1);

        // R4: significand sweep at moderate exponents, mixed signs
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                run_div({1'(i & 1), 8'(120 + (i % 8)), frac_pick(i)},
                        {1'(j & 1), 8'(118 + (j % 8)), frac_pick(j + 16)},
                        "R4", 1'b0);
            end
        end
        // R4: exact ties and exact quotients
        run_div(32'h3F800000, 32'h3F800000, "R4", 1'b0);
        run_div(32'h40C00000, 32'h40000000, "R4", 1'b0);
        run_div(32'h3F7FFFFF, 32'h3F800001, "R4", 1'b0);

        // R9: exponent boundary sweep, overflow and underflow
        for (int i = 0; i < 7; i++) begin
            for (int j = 0; j < 7; j++) begin
                automatic int el [7] = '{1, 2, 60, 127, 190, 253, 254};
                run_div({1'(j & 1), 8'(el[i]), (i % 2 == 0) ? 23'h7FFFFF : 23'h000000},
                        {1'(i & 1), 8'(el[j]), (j % 2 == 0) ? 23'h000000 : 23'h7FFFFF},
                        "R9", 1'b0);
            end
        end
        run_div(32'h7F7FFFFF, 32'h3F000000, "R9", 1'b0);
        run_div(32'h00800000, 32'h40000000, "R9", 1'b0);
        run_div(32'h00800000, 32'h3F800000, "R9", 1'b0);

        // R5..R8: special-operand class matrix with signs
        for (int ca = 0; ca < 5; ca++) begin
            for (int cb = 0; cb < 5; cb++) begin
                for (int sg = 0; sg < 4; sg++) begin
                    automatic logic [31:0] a = mk(ca, sg[0]);
                    automatic logic [31:0] b = mk(cb, sg[1]);
                    automatic logic [31:0] e = ref_div(a, b);
                    automatic string tag;
                    if (e == 32'h7FC00000)                 tag = "R7";
                    else if (cb <= 1 && ca == 2)           tag = "R5";
                    else if (cb == 3 && ca <= 2)           tag = "R6";
                    else                                   tag = "R8";
                    run_div(a, b, tag, 1'b0);
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule